// File: doc/BRIEF.md
# Sixteen-Bit Capture/Compare Timer

This block is a 16-bit timer for a peripheral subsystem. Its counter advances on a selected time base. The time base is either a one-cycle tick pulse from an external prescaler, or one chosen edge of an asynchronous external clock pin. When no time base is selected, the counter stops.

Two compare channels each hold a buffered value and an active value. The active value is matched against the counter, and each channel drives its own waveform pin. A capture path takes one of two input pins and passes it through a synchronizer, an optional glitch filter and an edge detector. On a capture event it records the counter value. Four event flags are each gated by a mask bit to form a single interrupt request.

Software reaches the block through a plain write port and a registered read port. The counter can run in three modes: free-running to 0xFFFF, cleared when it reaches the active compare A value, or fast PWM with a programmable TOP.

Top module: `capcmp_timer16`

## Requirements
- R1: After reset, the counter, both compare values, the capture register and the flags read as 0, TOP reads 0xFFFF, and `irq`, `wave_a` and `wave_b` are low.
- R2: The register addresses are 0 control, 1 counter, 2 compare A buffer, 3 compare B buffer, 4 capture (read only), 5 TOP, 6 flags, 7 mask. Reads return data one cycle after `rd_addr` is presented. A counter write takes priority over counting.
- R3: Control bits [1:0] select the time base: 0 none, 1 tick pulse, 2 external rising edge, 3 external falling edge. The counter advances by one per selected event and holds its value when the selection is 0. Events from an unselected source are ignored.
- R4: The external clock is sampled through a two-flop synchronizer, and only the selected edge advances the counter.
- R5: Control bits [3:2] select the mode: 0 normal (TOP = 0xFFFF), 1 clear on compare (TOP = active compare A), 2 fast PWM (TOP = TOP register). On an advance event with the counter at TOP, the counter goes to 0 and flag bit 0 is set.
- R6: On an advance event with the counter equal to a channel's active value, the flag is set: bit 1 for A, bit 2 for B.
- R7: In modes 0 and 1, a compare write updates the active value in the same cycle. In mode 2, the write goes only to the buffer, and the buffer is copied to the active value at the wrap.
- R8: In fast PWM mode, a waveform output goes high at the wrap and low on its compare match. In the other modes it toggles on each match.
- R9: Control bit 4 selects capture pin 0 or 1, and bit 6 selects the rising (1) or falling (0) edge. A capture event copies the counter into the capture register and sets flag bit 3. Activity on the unselected pin has no effect.
- R10: When control bit 5 is set, a new capture level is accepted only after it has held for 4 consecutive cycles, so shorter pulses cause no capture.
- R11: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged.
- R12: `irq` is high one cycle after any flag bit and its mask bit (same positions) are both set, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Registered read data |
| tick_in | input | 1 | Prescaled time-base pulse |
| ext_clk | input | 1 | Asynchronous external count clock |
| cap_pin | input | 2 | Capture input pins |
| wave_a | output | 1 | Channel A waveform |
| wave_b | output | 1 | Channel B waveform |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench targets several corner cases:
- **Counting past 0xFFFF.** A design that loses the overflow would leave flag 0 clear.
- **Compare value equal to TOP.** The match and the wrap fall on the same event; a design that drops one of them would set only one flag.
- **Compare write during a fast PWM period.** A design without buffering would match the new value within the current period.
- **Capture filtering and selection.** It sends a 3-cycle glitch with the filter on, and pulses on the unselected capture pin; a design that captures either would set flag 3.
- **External clock edges.** It checks that each external edge polarity counts only its own transition, before the opposite edge arrives.
- **Selective flag clearing.** Clearing one flag must leave the others set.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    CS_OFF      = 2'd0,
    CS_TICK     = 2'd1,
    CS_EXT_RISE = 2'd2,
    CS_EXT_FALL = 2'd3
  } clk_src_e;

  typedef enum logic [1:0] {
    MD_NORMAL    = 2'd0,
    MD_CLR_MATCH = 2'd1,
    MD_FAST_PWM  = 2'd2,
    MD_RSVD      = 2'd3
  } tmr_mode_e;

  typedef struct packed {
    logic      spare;
    logic      cap_rise;
    logic      filt_en;
    logic      cap_sel;
    tmr_mode_e mode;
    clk_src_e  clk_src;
  } ctrl_t;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_COUNT = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMPA  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMPB  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CAPT  = 3'd4;
  localparam logic [ADDR_W-1:0] A_TOP   = 3'd5;
  localparam logic [ADDR_W-1:0] A_FLAGS = 3'd6;
  localparam logic [ADDR_W-1:0] A_MASK  = 3'd7;

  localparam int FLAG_OVF = 0;
  localparam int FLAG_CMA = 1;
  localparam int FLAG_CMB = 2;
  localparam int FLAG_CAP = 3;
  localparam int NFLAGS   = 4;

endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/tmr_noise_filter.sv
module tmr_noise_filter #(
  parameter int STABLE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic d,
  output logic q
);
  localparam int CW = $clog2(STABLE_CYCLES + 1);

  logic          filt_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      filt_q <= 1'b0;
      run_q  <= '0;
    end else if (d == filt_q) begin
      run_q <= '0;
    end else if (run_q == CW'(STABLE_CYCLES - 1)) begin
      filt_q <= d;
      run_q  <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign q = en ? filt_q : d;
endmodule

// File: rtl/tmr_cmp_channel.sv
module tmr_cmp_channel #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         buf_wr,
  input  logic [W-1:0] wr_data,
  input  logic         pwm_mode,
  input  logic         tick,
  input  logic         wrap,
  input  logic [W-1:0] cnt,
  output logic [W-1:0] buf_q,
  output logic [W-1:0] act_q,
  output logic         match,
  output logic         wave
);
  assign match = tick && (cnt == act_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q <= '0;
      act_q <= '0;
      wave  <= 1'b0;
    end else begin
      if (buf_wr) buf_q <= wr_data;

      if (buf_wr && !pwm_mode)      act_q <= wr_data;
      else if (pwm_mode && wrap)    act_q <= buf_q;

      if (pwm_mode) begin
        if (wrap)       wave <= 1'b1;
        else if (match) wave <= 1'b0;
      end else if (match) begin
        wave <= ~wave;
      end
    end
  end
endmodule

// File: rtl/capcmp_timer16.sv
module capcmp_timer16
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int FILT_CYCLES = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  input  logic              tick_in,
  input  logic              ext_clk,
  input  logic [1:0]        cap_pin,
  output logic              wave_a,
  output logic              wave_b,
  output logic              irq
);
  localparam int NUM_CMP = 2;
  localparam int CTRL_W  = $bits(ctrl_t);

  ctrl_t               ctrl_q;
  logic [CNT_W-1:0]    cnt_q, top_q, capt_q, top_val;
  logic [NFLAGS-1:0]   flags_q, mask_q, flag_set, flag_clr;
  logic                irq_q;

  // time base
  logic ext_lvl, ext_prev, tick, at_top, wrap, cnt_wr, pwm_mode;

  tmr_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk(clk), .rst(rst), .d(ext_clk), .q(ext_lvl));

  always_ff @(posedge clk) begin
    if (rst) ext_prev <= 1'b0;
    else     ext_prev <= ext_lvl;
  end

  always_comb begin
    unique case (ctrl_q.clk_src)
      CS_TICK:     tick = tick_in;
      CS_EXT_RISE: tick = ext_lvl & ~ext_prev;
      CS_EXT_FALL: tick = ~ext_lvl & ext_prev;
      default:     tick = 1'b0;
    endcase
  end

  // compare channels
  logic [CNT_W-1:0] cmp_buf [NUM_CMP];
  logic [CNT_W-1:0] cmp_act [NUM_CMP];
  logic [NUM_CMP-1:0] cmp_match, cmp_wave, cmp_wr;

  assign pwm_mode = (ctrl_q.mode == MD_FAST_PWM);

  always_comb begin
    unique case (ctrl_q.mode)
      MD_CLR_MATCH: top_val = cmp_act[0];
      MD_FAST_PWM:  top_val = top_q;
      default:      top_val = '1;
    endcase
  end

  assign at_top = (cnt_q == top_val);
  assign wrap   = tick && at_top;
  assign cnt_wr = wr_en && (wr_addr == A_COUNT);

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
    assign cmp_wr[k] = wr_en && (wr_addr == A_CMPA + ADDR_W'(k));
    tmr_cmp_channel #(.W(CNT_W)) u_ch (
      .clk(clk), .rst(rst), .buf_wr(cmp_wr[k]), .wr_data(wr_data),
      .pwm_mode(pwm_mode), .tick(tick), .wrap(wrap), .cnt(cnt_q),
      .buf_q(cmp_buf[k]), .act_q(cmp_act[k]), .match(cmp_match[k]),
      .wave(cmp_wave[k]));
  end

  // counter
  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (cnt_wr) cnt_q <= wr_data;
    else if (tick)   cnt_q <= at_top ? '0 : cnt_q + 1'b1;
  end

  // capture path
  logic cap_raw, cap_sync, cap_lvl, cap_prev, cap_evt;

  assign cap_raw = cap_pin[ctrl_q.cap_sel];

  tmr_sync #(.STAGES(SYNC_STAGES)) u_cap_sync (
    .clk(clk), .rst(rst), .d(cap_raw), .q(cap_sync));

  tmr_noise_filter #(.STABLE_CYCLES(FILT_CYCLES)) u_cap_filt (
    .clk(clk), .rst(rst), .en(ctrl_q.filt_en), .d(cap_sync), .q(cap_lvl));

  always_ff @(posedge clk) begin
    if (rst) cap_prev <= 1'b0;
    else     cap_prev <= cap_lvl;
  end

  assign cap_evt = ctrl_q.cap_rise ? (cap_lvl & ~cap_prev) : (~cap_lvl & cap_prev);

  always_ff @(posedge clk) begin
    if (rst)          capt_q <= '0;
    else if (cap_evt) capt_q <= cnt_q;
  end

  // control, top, flags, mask
  assign flag_set[FLAG_OVF] = wrap;
  assign flag_set[FLAG_CMA] = cmp_match[0];
  assign flag_set[FLAG_CMB] = cmp_match[1];
  assign flag_set[FLAG_CAP] = cap_evt;
  assign flag_clr = (wr_en && wr_addr == A_FLAGS) ? wr_data[NFLAGS-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      top_q   <= '1;
      flags_q <= '0;
      mask_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (wr_en && wr_addr == A_CTRL) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
      if (wr_en && wr_addr == A_TOP)  top_q  <= wr_data;
      if (wr_en && wr_addr == A_MASK) mask_q <= wr_data[NFLAGS-1:0];
      flags_q <= (flags_q & ~flag_clr) | flag_set;
      irq_q   <= |(flags_q & mask_q);
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      unique case (rd_addr)
        A_CTRL:  rd_data <= {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};
        A_COUNT: rd_data <= cnt_q;
        A_CMPA:  rd_data <= cmp_buf[0];
        A_CMPB:  rd_data <= cmp_buf[1];
        A_CAPT:  rd_data <= capt_q;
        A_TOP:   rd_data <= top_q;
        A_FLAGS: rd_data <= {{(CNT_W-NFLAGS){1'b0}}, flags_q};
        default: rd_data <= {{(CNT_W-NFLAGS){1'b0}}, mask_q};
      endcase
    end
  end

  assign wave_a = cmp_wave[0];
  assign wave_b = cmp_wave[1];
  assign irq    = irq_q;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic [1:0]   clk_src,
  input logic         tick,
  input logic         wrap,
  input logic         cnt_wr,
  input logic [W-1:0] cnt_q,
  input logic         cap_evt,
  input logic [W-1:0] capt_q,
  input logic [3:0]   flags_q,
  input logic [3:0]   mask_q,
  input logic         irq,
  input logic         cmpa_wr,
  input logic         pwm_mode,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] act_a
);
  assert_hold_no_clock_R3: assert property (@(posedge clk) disable iff (rst)
    (clk_src == 2'd0 && !cnt_wr) |=> $stable(cnt_q));

  assert_step_by_one_R3: assert property (@(posedge clk) disable iff (rst)
    (tick && !wrap && !cnt_wr) |=> (cnt_q == W'($past(cnt_q) + 1'b1)));

  assert_wrap_zero_flag_R5: assert property (@(posedge clk) disable iff (rst)
    (wrap && !cnt_wr) |=> (cnt_q == '0 && flags_q[0]));

  assert_capture_copy_R9: assert property (@(posedge clk) disable iff (rst)
    cap_evt |=> (capt_q == $past(cnt_q) && flags_q[3]));

  assert_cmp_immediate_R7: assert property (@(posedge clk) disable iff (rst)
    (cmpa_wr && !pwm_mode) |=> (act_a == $past(wr_data)));

  assert_irq_gating_R12: assert property (@(posedge clk) disable iff (rst)
    irq == $past(|(flags_q & mask_q)));
endmodule

bind capcmp_timer16 tmr_checker #(.W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .clk_src(ctrl_q.clk_src), .tick(tick), .wrap(wrap),
  .cnt_wr(cnt_wr), .cnt_q(cnt_q), .cap_evt(cap_evt), .capt_q(capt_q),
  .flags_q(flags_q), .mask_q(mask_q), .irq(irq), .cmpa_wr(cmp_wr[0]),
  .pwm_mode(pwm_mode), .wr_data(wr_data), .act_a(cmp_act[0]));

// File: tb/tb_capcmp_timer16.sv
`timescale 1ns/1ps
module tb_capcmp_timer16;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        tick_in = 1'b0;
  logic        ext_clk = 1'b0;
  logic [1:0]  cap_pin = 2'b00;
  logic        wave_a, wave_b, irq;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  capcmp_timer16 dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tick_in(tick_in), .ext_clk(ext_clk),
    .cap_pin(cap_pin), .wave_a(wave_a), .wave_b(wave_b), .irq(irq));

  typedef struct packed {
    logic [1:0]  mode;
    logic [15:0] start;
    logic [15:0] cmpa;
    logic [15:0] cmpb;
    logic [15:0] top;
    logic [7:0]  ticks;
    logic [15:0] exp_cnt;
    logic [3:0]  exp_flags;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 16'h0000, 16'd5, 16'd9, 16'hFFFF, 8'd3, 16'd3, 4'h0},
    '{2'd0, 16'h0000, 16'd2, 16'd9, 16'hFFFF, 8'd3, 16'd3, 4'h2},
    '{2'd1, 16'h0000, 16'd4, 16'd1, 16'hFFFF, 8'd5, 16'd0, 4'h7},
    '{2'd1, 16'h0000, 16'd4, 16'd9, 16'hFFFF, 8'd7, 16'd2, 4'h3},
    '{2'd2, 16'h0000, 16'd1, 16'd9, 16'd3,    8'd4, 16'd0, 4'h3},
    '{2'd2, 16'h0000, 16'd1, 16'd9, 16'd3,    8'd2, 16'd2, 4'h2},
    '{2'd0, 16'hFFFE, 16'd5, 16'd9, 16'hFFFF, 8'd2, 16'd0, 4'h1},
    '{2'd2, 16'h0000, 16'd3, 16'd9, 16'd3,    8'd4, 16'd0, 4'h3}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic pulse_tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_in = 1'b1;
      @(negedge clk); tick_in = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    idle(3);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    rd(3'd1, v); check("R1 count", v, 16'h0);
    rd(3'd6, v); check("R1 flags", v, 16'h0);
    rd(3'd4, v); check("R1 capture", v, 16'h0);
    rd(3'd2, v); check("R1 cmpa", v, 16'h0);
    rd(3'd5, v); check("R1 top", v, 16'hFFFF);
    check("R1 irq/wave", {13'd0, irq, wave_a, wave_b}, 16'h0);

    // vector table: R3 R5 R6 counting, wrap and match
    for (int i = 0; i < NV; i++) begin
      wr(3'd0, 16'h0);
      wr(3'd1, VECS[i].start);
      wr(3'd2, VECS[i].cmpa);
      wr(3'd3, VECS[i].cmpb);
      wr(3'd5, VECS[i].top);
      wr(3'd6, 16'hF);
      wr(3'd0, {12'd0, VECS[i].mode, 2'd1});
      pulse_tick(VECS[i].ticks);
      wr(3'd0, 16'h0);
      rd(3'd1, v); check($sformatf("R3/R5 vec%0d count", i), v, VECS[i].exp_cnt);
      rd(3'd6, v); check($sformatf("R5/R6 vec%0d flags", i), v, {12'd0, VECS[i].exp_flags});
    end

    // R3 holds with no source; R2 counter write
    wr(3'd1, 16'd7);
    rd(3'd1, v); check("R2 count write", v, 16'd7);
    pulse_tick(2);
    rd(3'd1, v); check("R3 no source hold", v, 16'd7);
    // R3 ext activity ignored when tick selected
    wr(3'd0, 16'h1);
    ext_clk = 1'b1; idle(6); ext_clk = 1'b0; idle(6);
    wr(3'd0, 16'h0);
    rd(3'd1, v); check("R3 unselected ext ignored", v, 16'd7);

    // R4 external rising edge
    wr(3'd1, 16'd0);
    wr(3'd0, 16'h2);
    ext_clk = 1'b1; idle(6);
    rd(3'd1, v); check("R4 rise counted", v, 16'd1);
    ext_clk = 1'b0; idle(6);
    rd(3'd1, v); check("R4 fall ignored in rise mode", v, 16'd1);
    // R4 external falling edge
    wr(3'd0, 16'h0);
    wr(3'd1, 16'd0);
    wr(3'd0, 16'h3);
    ext_clk = 1'b1; idle(6);
    rd(3'd1, v); check("R4 rise ignored in fall mode", v, 16'd0);
    ext_clk = 1'b0; idle(6);
    rd(3'd1, v); check("R4 fall counted", v, 16'd1);
    wr(3'd0, 16'h0);

    // R7 double buffer in fast PWM, R8 waveform
    wr(3'd1, 16'd0);
    wr(3'd2, 16'd5);
    wr(3'd3, 16'd9);
    wr(3'd5, 16'd9);
    wr(3'd6, 16'hF);
    wr(3'd0, 16'h9);
    wr(3'd2, 16'd2);
    pulse_tick(3);
    rd(3'd6, v); check("R7 buffered value not yet active", v, 16'h0);
    pulse_tick(7);
    wr(3'd6, 16'hF);
    check("R8 wave high after wrap", {15'd0, wave_a}, 16'd1);
    pulse_tick(3);
    rd(3'd6, v); check("R7 new value active after wrap", v, 16'h2);
    check("R8 wave low after match", {15'd0, wave_a}, 16'd0);
    wr(3'd0, 16'h0);

    // R9 capture on pin 0 rising edge
    wr(3'd0, 16'h40);
    wr(3'd1, 16'h1234);
    wr(3'd6, 16'hF);
    cap_pin[0] = 1'b1; idle(8);
    rd(3'd4, v); check("R9 capture value pin0", v, 16'h1234);
    rd(3'd6, v); check("R9 capture flag", v, 16'h8);
    cap_pin[0] = 1'b0; idle(8);
    wr(3'd6, 16'hF);
    cap_pin[1] = 1'b1; idle(8); cap_pin[1] = 1'b0; idle(8);
    rd(3'd6, v); check("R9 unselected pin ignored", v, 16'h0);
    wr(3'd0, 16'h50);
    wr(3'd1, 16'h0ABC);
    cap_pin[1] = 1'b1; idle(8);
    rd(3'd4, v); check("R9 capture value pin1", v, 16'h0ABC);
    // R9 falling edge
    wr(3'd0, 16'h10);
    wr(3'd1, 16'h0055);
    wr(3'd6, 16'hF);
    rd(3'd6, v); check("R9 no event while high", v, 16'h0);
    cap_pin[1] = 1'b0; idle(8);
    rd(3'd4, v); check("R9 falling capture value", v, 16'h0055);
    rd(3'd6, v); check("R9 falling capture flag", v, 16'h8);

    // R10 noise filter
    wr(3'd0, 16'h60);
    idle(8);
    wr(3'd6, 16'hF);
    wr(3'd1, 16'h0100);
    @(negedge clk); cap_pin[0] = 1'b1; idle(3); cap_pin[0] = 1'b0; idle(10);
    rd(3'd6, v); check("R10 short glitch rejected", v, 16'h0);
    cap_pin[0] = 1'b1; idle(12);
    rd(3'd6, v); check("R10 stable level captured", v, 16'h8);
    rd(3'd4, v); check("R10 capture value", v, 16'h0100);
    cap_pin[0] = 1'b0; idle(12);
    wr(3'd0, 16'h0);

    // R11 write-one-to-clear and R12 irq masking
    wr(3'd6, 16'hF);
    wr(3'd1, 16'd0);
    wr(3'd2, 16'd0);
    wr(3'd3, 16'd0);
    wr(3'd0, 16'h1);
    pulse_tick(1);
    wr(3'd0, 16'h0);
    wr(3'd7, 16'h0);
    idle(2);
    check("R12 irq low when masked", {15'd0, irq}, 16'd0);
    wr(3'd7, 16'h2);
    idle(2);
    check("R12 irq high with flag and mask", {15'd0, irq}, 16'd1);
    wr(3'd6, 16'h4);
    rd(3'd6, v); check("R11 selective clear", v, 16'h2);
    wr(3'd6, 16'h2);
    idle(2);
    rd(3'd6, v); check("R11 all cleared", v, 16'h0);
    check("R12 irq low after clear", {15'd0, irq}, 16'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule